// File: doc/BRIEF.md
# Indirect MAC Configuration Register Bridge

This block lets a 32-bit host register bus reach a bank of 16-bit MAC configuration registers through two host words only: a staging word and a command word. To write an internal register, the host first loads the value into the staging word and then writes the command word with its top bit set. To read, the host writes the command word with its top bit clear, waits for the access to finish, and then reads the result from the staging word.

Every internal access takes a fixed, parameterized number of cycles. During that window a busy flag, visible in the command word, is high, and all host writes are dropped. The register bank inside the block holds the operating mode, the receive/transmit options, the maximum frame length, the inter-frame gap, the 48-bit station address, and two management words. It drives all of them straight out to the MAC. It also mirrors a read-only status word that comes in from the MAC.

Top module: `mac_reg_bridge`

## Requirements
- R1: After reset, busy is 0, the staging word reads 0, mode_o, ctrl_o, station_o, mdio_ctl_o and mdio_data_o are 0, max_len_o is MAXLEN_RST (1518) and ipg_o is IPG_RST (12).
- R2: A host write to host offset 4 with bit 31 set writes staging bits [15:0] into the internal register selected by command bits [OFF_W-1:0]. The register output changes exactly ACCESS_CYCLES clock edges after the edge that accepted the command.
- R3: A host write to host offset 4 with bit 31 clear loads the selected internal register, zero-extended, into the staging word (host offset 0) when the access completes.
- R4: Reading host offset 4 returns busy in bit 30, the last command kind in bit 31 and the last offset in bits [OFF_W-1:0]. Busy is high for exactly ACCESS_CYCLES cycles after each accepted command.
- R5: While busy, host writes to the staging word and to the command word are ignored.
- R6: Internal offsets outside the map (odd offsets, 0x6, 0x10, and anything above 0x16) read as 0, and writes to them change nothing.
- R7: Internal offset 0x12 reads stat_i as it is at completion. Writes to it change nothing.
- R8: Offset 0x0 holds mode bits 3:0 (0 gigabit, 1 flow control, 2 receive enable, 3 transmit enable), driven on mode_o. Bits 15:4 read 0.
- R9: Offset 0x2 holds option bits 8:0 (0 promiscuous, 1 discard received FCS, 2 omit transmit FCS, 3 receive pause, 4 multicast, 5 half duplex, 6 drop control frames, 7 broadcast, 8 short frames), driven on ctrl_o. Bits 15:9 read 0.
- R10: The station address words at offsets 0xA, 0xC and 0xE form station_o[47:32], [31:16] and [15:0]. Offset 0x4 drives max_len_o, 0x8 drives ipg_o, 0x14 drives mdio_ctl_o and 0x16 drives mdio_data_o, all 16 bits.
- R11: hb_ready is always 1. Read data appears with hb_rvalid one cycle after the read is accepted. Host offsets other than 0 and 4 read 0, and writes to them are ignored.
- R12: Command bits [30:OFF_W] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_valid | input | 1 | Host transfer request |
| hb_ready | output | 1 | Host transfer accepted (always 1) |
| hb_write | input | 1 | 1 for a write, 0 for a read |
| hb_addr | input | HA_W | Host byte offset, word aligned |
| hb_wdata | input | 32 | Host write data |
| hb_rvalid | output | 1 | Read data valid |
| hb_rdata | output | 32 | Read data |
| stat_i | input | 16 | Status word from the MAC |
| mode_o | output | 4 | Mode bits |
| ctrl_o | output | 9 | Receive/transmit option bits |
| max_len_o | output | 16 | Maximum frame length |
| ipg_o | output | 16 | Inter-frame gap |
| station_o | output | 48 | Station address |
| mdio_ctl_o | output | 16 | Management control word |
| mdio_data_o | output | 16 | Management data word |

## Verification
The bench builds the bridge with ACCESS_CYCLES = 5 and otherwise keeps the defaults (OFF_W = 8, HA_W = 4). A short window keeps each access cheap, so a long random mix of reads and writes fits in the run. It still makes the edges of the busy window clearly separate from a one-cycle access. Because OFF_W = 8, the command word has junk bits above the offset field that the random stimulus fills in. Odd and unmapped offsets are also reachable within that field.

// File: rtl/mac_reg_bridge.sv
module mac_reg_bridge #(
  parameter int ACCESS_CYCLES = 8,
  parameter int OFF_W = 8,
  parameter int HA_W = 4,
  parameter logic [15:0] MAXLEN_RST = 16'd1518,
  parameter logic [15:0] IPG_RST = 16'd12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hb_valid,
  output logic            hb_ready,
  input  logic            hb_write,
  input  logic [HA_W-1:0] hb_addr,
  input  logic [31:0]     hb_wdata,
  output logic            hb_rvalid,
  output logic [31:0]     hb_rdata,
  input  logic [15:0]     stat_i,
  output logic [3:0]      mode_o,
  output logic [8:0]      ctrl_o,
  output logic [15:0]     max_len_o,
  output logic [15:0]     ipg_o,
  output logic [47:0]     station_o,
  output logic [15:0]     mdio_ctl_o,
  output logic [15:0]     mdio_data_o
);
  localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYCLES - 1);
  localparam logic [HA_W-1:0] HA_STAGE = '0;
  localparam logic [HA_W-1:0] HA_CMD = HA_W'(4);
  localparam logic [OFF_W-1:0] O_MODE = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] O_CTRL = OFF_W'(8'h02);
  localparam logic [OFF_W-1:0] O_MLEN = OFF_W'(8'h04);
  localparam logic [OFF_W-1:0] O_IPG  = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] O_SA0  = OFF_W'(8'h0A);
  localparam logic [OFF_W-1:0] O_SA1  = OFF_W'(8'h0C);
  localparam logic [OFF_W-1:0] O_SA2  = OFF_W'(8'h0E);
  localparam logic [OFF_W-1:0] O_STAT = OFF_W'(8'h12);
  localparam logic [OFF_W-1:0] O_MCTL = OFF_W'(8'h14);
  localparam logic [OFF_W-1:0] O_MDAT = OFF_W'(8'h16);

  logic             busy_q, we_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] off_q;
  logic [15:0]      data_q;
  logic [15:0]      sa0_q, sa1_q, sa2_q;
  logic             unused_hi;

  assign unused_hi = ^hb_wdata[30:16];
  assign hb_ready  = 1'b1;

  wire host_wr = hb_valid & hb_write;
  wire host_rd = hb_valid & ~hb_write;
  wire stage_wr = host_wr & (hb_addr == HA_STAGE) & ~busy_q;
  wire cmd_wr   = host_wr & (hb_addr == HA_CMD) & ~busy_q;
  wire done     = busy_q & (cnt_q == '0);

  // internal register bus
  wire             ib_wr    = done & we_q;
  wire             ib_rd    = done & ~we_q;
  wire [OFF_W-1:0] ib_addr  = off_q;
  wire [15:0]      ib_wdata = data_q;
  logic [15:0]     ib_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      off_q  <= '0;
      we_q   <= 1'b0;
    end else if (cmd_wr) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
      off_q  <= hb_wdata[OFF_W-1:0];
      we_q   <= hb_wdata[31];
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (stage_wr) data_q <= hb_wdata[15:0];
    else if (ib_rd)    data_q <= ib_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o      <= '0;
      ctrl_o      <= '0;
      max_len_o   <= MAXLEN_RST;
      ipg_o       <= IPG_RST;
      sa0_q       <= '0;
      sa1_q       <= '0;
      sa2_q       <= '0;
      mdio_ctl_o  <= '0;
      mdio_data_o <= '0;
    end else if (ib_wr) begin
      case (ib_addr)
        O_MODE: mode_o      <= ib_wdata[3:0];
        O_CTRL: ctrl_o      <= ib_wdata[8:0];
        O_MLEN: max_len_o   <= ib_wdata;
        O_IPG:  ipg_o       <= ib_wdata;
        O_SA0:  sa0_q       <= ib_wdata;
        O_SA1:  sa1_q       <= ib_wdata;
        O_SA2:  sa2_q       <= ib_wdata;
        O_MCTL: mdio_ctl_o  <= ib_wdata;
        O_MDAT: mdio_data_o <= ib_wdata;
        default: ;
      endcase
    end
  end

  assign station_o = {sa0_q, sa1_q, sa2_q};

  always_comb begin
    case (ib_addr)
      O_MODE:  ib_rdata = {12'b0, mode_o};
      O_CTRL:  ib_rdata = {7'b0, ctrl_o};
      O_MLEN:  ib_rdata = max_len_o;
      O_IPG:   ib_rdata = ipg_o;
      O_SA0:   ib_rdata = sa0_q;
      O_SA1:   ib_rdata = sa1_q;
      O_SA2:   ib_rdata = sa2_q;
      O_STAT:  ib_rdata = stat_i;
      O_MCTL:  ib_rdata = mdio_ctl_o;
      O_MDAT:  ib_rdata = mdio_data_o;
      default: ib_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_rvalid <= 1'b0;
      hb_rdata  <= '0;
    end else begin
      hb_rvalid <= host_rd;
      if (host_rd) begin
        case (hb_addr)
          HA_STAGE: hb_rdata <= {16'b0, data_q};
          HA_CMD:   hb_rdata <= {we_q, busy_q, {(30-OFF_W){1'b0}}, off_q};
          default:  hb_rdata <= '0;
        endcase
      end
    end
  end
endmodule

module mac_reg_bridge_chk #(
  parameter int ACCESS_CYCLES = 8,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hb_valid,
  input logic             hb_write,
  input logic             hb_rvalid,
  input logic             busy_q,
  input logic [OFF_W-1:0] off_q,
  input logic [15:0]      data_q,
  input logic [3:0]       mode_o,
  input logic [47:0]      station_o
);
  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  a_r4_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> run_q < 32'(ACCESS_CYCLES));
  a_r4_busy_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(run_q) == 32'(ACCESS_CYCLES - 1));
  a_r5_cmd_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hb_valid && hb_write) |=> $stable(off_q));
  a_r2_regs_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> ($stable(mode_o) && $stable(station_o)));
  a_r3_stage_hold_mid_access: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(data_q) || !busy_q));
  a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_valid && !hb_write) |=> hb_rvalid);
  a_r11_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(hb_valid && !hb_write) |=> !hb_rvalid);
endmodule

bind mac_reg_bridge mac_reg_bridge_chk #(.ACCESS_CYCLES(ACCESS_CYCLES), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/mac_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module mac_reg_bridge_tb_top;
  localparam int N = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hb_valid = 1'b0, hb_write = 1'b0, hb_ready, hb_rvalid;
  logic [3:0] hb_addr = '0;
  logic [31:0] hb_wdata = '0, hb_rdata;
  logic [15:0] stat_i = 16'h5A3C;
  logic [3:0] mode_o;
  logic [8:0] ctrl_o;
  logic [15:0] max_len_o, ipg_o, mdio_ctl_o, mdio_data_o;
  logic [47:0] station_o;
  int checks = 0, errors = 0;
  logic [15:0] mdl [0:255];

  always #2.5 clk = ~clk;

  mac_reg_bridge #(.ACCESS_CYCLES(N)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wmask(input logic [7:0] o);
    case (o)
      8'h00: return 16'h000F;
      8'h02: return 16'h01FF;
      8'h04, 8'h08, 8'h0A, 8'h0C, 8'h0E, 8'h14, 8'h16: return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input logic [7:0] o);
    if (o == 8'h12) return stat_i;
    return mdl[o] & wmask(o);
  endfunction

  task automatic hwr(input logic [3:0] a, input logic [31:0] d);
    hb_valid = 1; hb_write = 1; hb_addr = a; hb_wdata = d;
    @(posedge clk); @(negedge clk);
    hb_valid = 0; hb_write = 0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [31:0] d);
    hb_valid = 1; hb_write = 0; hb_addr = a;
    @(posedge clk); @(negedge clk);
    hb_valid = 0;
    chk("R11 rvalid", {63'b0, hb_rvalid}, 64'd1);
    d = hb_rdata;
  endtask

  task automatic wait_idle(output int polls);
    logic [31:0] w;
    polls = 0;
    for (int i = 0; i < 64; i++) begin
      hrd(4'h4, w);
      if (!w[30]) break;
      polls++;
    end
  endtask

  task automatic cmd(input logic [7:0] o, input logic we, input logic [31:0] junk);
    hwr(4'h4, {we, junk[30:8], o});
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R8 mode"}, {60'b0, mode_o}, {60'b0, mdl[8'h00][3:0]});
    chk({tag, " R9 ctrl"}, {55'b0, ctrl_o}, {55'b0, mdl[8'h02][8:0]});
    chk({tag, " R10 station"}, {16'b0, station_o}, {16'b0, mdl[8'h0A], mdl[8'h0C], mdl[8'h0E]});
    chk({tag, " R10 misc"}, {max_len_o, ipg_o, mdio_ctl_o, mdio_data_o},
        {mdl[8'h04], mdl[8'h08], mdl[8'h14], mdl[8'h16]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int polls;
    void'($urandom(32'h1D2C3B4A));
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    mdl[8'h04] = 16'd1518;
    mdl[8'h08] = 16'd12;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    hrd(4'h4, w); chk("R1 busy", {63'b0, w[30]}, 64'd0);
    hrd(4'h0, w); chk("R1 stage", {32'b0, w}, 64'd0);
    chk_outs("R1");
    chk("R11 ready", {63'b0, hb_ready}, 64'd1);

    // R2 exact latency on mode, with junk high bits (R12)
    hwr(4'h0, 32'hFFFF_FFF5);
    cmd(8'h00, 1'b1, 32'h2AAA_AA00);
    for (int k = 0; k < N - 1; k++) @(negedge clk);
    chk("R2 mode before end", {60'b0, mode_o}, 64'd0);
    @(negedge clk);
    chk("R2 R12 mode at end", {60'b0, mode_o}, 64'h5);
    mdl[8'h00] = 16'hFFF5;
    wait_idle(polls);

    // R4 busy window length and readback fields
    hwr(4'h0, 32'h0000_1234);
    cmd(8'h16, 1'b1, 32'h0);
    wait_idle(polls);
    mdl[8'h16] = 16'h1234;
    chk("R4 busy cycles", 64'(polls), 64'(N));
    hrd(4'h4, w);
    chk("R4 cmd readback", {32'b0, w}, {32'b0, 32'h8000_0016});

    // R3 read back and R8 upper bits zero
    cmd(8'h00, 1'b0, 32'h0);
    wait_idle(polls);
    hrd(4'h0, w); chk("R3 R8 mode read", {32'b0, w}, 64'h5);

    // R5 writes ignored while busy
    hwr(4'h0, 32'h0000_ABCD);
    cmd(8'h02, 1'b1, 32'h0);
    hwr(4'h0, 32'h0000_7777);
    cmd(8'h00, 1'b1, 32'h0);
    wait_idle(polls);
    mdl[8'h02] = 16'hABCD;
    chk("R5 R9 ctrl", {55'b0, ctrl_o}, {55'b0, 9'h1CD});
    chk("R5 mode kept", {60'b0, mode_o}, 64'h5);
    hrd(4'h0, w); chk("R5 stage kept", {32'b0, w}, 64'hABCD);
    hrd(4'h4, w); chk("R5 offset kept", {56'b0, w[7:0]}, 64'h02);

    // R6 unmapped write discarded, read zero
    hwr(4'h0, 32'h0000_FFFF);
    cmd(8'h06, 1'b1, 32'h0);
    wait_idle(polls);
    cmd(8'h06, 1'b0, 32'h0);
    wait_idle(polls);
    hrd(4'h0, w); chk("R6 unmapped read", {32'b0, w}, 64'h0);
    chk_outs("R6");

    // R7 status mirror and read-only
    hwr(4'h0, 32'h0000_0000);
    cmd(8'h12, 1'b1, 32'h0);
    wait_idle(polls);
    stat_i = 16'hC3E1;
    cmd(8'h12, 1'b0, 32'h0);
    wait_idle(polls);
    hrd(4'h0, w); chk("R7 status", {32'b0, w}, 64'hC3E1);

    // R11 other host offsets
    hwr(4'h8, 32'hDEAD_BEEF);
    hrd(4'h8, w); chk("R11 other offset", {32'b0, w}, 64'h0);
    hrd(4'h0, w); chk("R11 stage unchanged", {32'b0, w}, 64'hC3E1);

    // random mix
    for (int it = 0; it < 200; it++) begin
      logic [7:0] o;
      logic we;
      logic [31:0] d;
      case ($urandom % 16)
        0: o = 8'h00; 1: o = 8'h02; 2: o = 8'h04; 3: o = 8'h08;
        4: o = 8'h0A; 5: o = 8'h0C; 6: o = 8'h0E; 7: o = 8'h12;
        8: o = 8'h14; 9: o = 8'h16; 10: o = 8'h06; 11: o = 8'h10;
        12: o = 8'h01; 13: o = 8'h0B; 14: o = 8'h18; default: o = 8'hFE;
      endcase
      we = $urandom % 2;
      d = $urandom;
      stat_i = 16'($urandom);
      if (we) begin
        hwr(4'h0, d);
        cmd(o, 1'b1, $urandom);
        wait_idle(polls);
        mdl[o] = (mdl[o] & ~wmask(o)) | (d[15:0] & wmask(o));
        chk_outs("R2 R6 R12 rand");
      end else begin
        cmd(o, 1'b0, $urandom);
        wait_idle(polls);
        hrd(4'h0, w);
        chk("R3 R6 R7 rand read", {32'b0, w}, {48'b0, exp_rd(o)});
      end
      chk("R4 rand busy", 64'(polls), 64'(N));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule